// File: doc/BRIEF.md
# March Memory Self-Test Engine

This block is a built-in self-test controller for a group of identical synchronous single-port RAMs. After a one-cycle start pulse it takes over the address, write-data and write-enable inputs of every attached RAM through a multiplexer. It then applies an eleven-operation-per-cell March sequence to all of them at once. Each RAM's read data is compared with the value the sequence expects. A mismatch on any RAM sets a sticky fail bit that belongs to that RAM alone.

The March pass is repeated over several data backgrounds. Each background is a word pattern with a different spacing of alternating bits. A short between two bits of the same word therefore shows up under at least one background.

The engine works when the RAM's read data arrives one clock after the read address. While the engine is idle, each RAM's functional inputs reach the RAM unchanged. Retention and refresh testing of dynamic cells is not part of this block.

Top module: `mbist_engine`

## Requirements
- R1: While no test is running, each RAM's ram_addr, ram_wdata and ram_we slices equal the matching sys_addr, sys_wdata and sys_we slices, combinationally.
- R2: start is accepted only when the engine is idle, meaning neither sequencing nor waiting for the last compare. An accepted start clears done and every fail_vec bit. A start that arrives while a test is running has no effect on the sequence, on its timing or on its result.
- R3: For each background the engine runs seven elements, in this order and direction: up(w0), up(r0,w1), up(r1,w0), up(r0), down(r0,w1), down(r1,w0), up(r0). "up" counts addresses from 0 to 2^ADDR_W-1. "down" counts from 2^ADDR_W-1 to 0. Both operations of a two-operation element are applied to one address before the address moves.
- R4: There are $clog2(DATA_W)+1 backgrounds, used in index order k = 0, 1, 2, and so on. Background 0 is all zeros. For k of 1 or more, bit i of background k is 1 exactly when bit k-1 of i is 0, which gives 0x55, 0x33 and 0x0F for DATA_W = 8. A "0" in R3 stands for the background and a "1" for its bitwise complement.
- R5: The engine presents one operation per clock on the shared ports of all RAMs. ram_we is high for a write, with the data on ram_wdata, and low for a read. The first operation appears in the cycle after the start is accepted, and operations follow with no idle cycles.
- R6: The read data of each RAM is compared with the expected word in the cycle after the read address was presented. A mismatch sets bit r of fail_vec for RAM r only, and that bit stays set until the next accepted start.
- R7: fail is the OR of all fail_vec bits.
- R8: done rises exactly 11 * 2^ADDR_W * ($clog2(DATA_W)+1) + 1 clock edges after the edge that accepted start. With the default parameters this is 705 edges. At that moment fail_vec already holds the result of the final compare. done and fail_vec then hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a test |
| done | output | 1 | Test finished; result is valid |
| fail | output | 1 | At least one RAM failed |
| fail_vec | output | NUM_RAMS | Per-RAM sticky fail bits |
| sys_addr | input | NUM_RAMS*ADDR_W | Functional addresses, one slice per RAM |
| sys_wdata | input | NUM_RAMS*DATA_W | Functional write data per RAM |
| sys_we | input | NUM_RAMS | Functional write enables per RAM |
| ram_addr | output | NUM_RAMS*ADDR_W | Address to each RAM |
| ram_wdata | output | NUM_RAMS*DATA_W | Write data to each RAM |
| ram_we | output | NUM_RAMS | Write enable to each RAM |
| ram_rdata | input | NUM_RAMS*DATA_W | Read data from each RAM, one cycle after the address |

## Verification
The compare for the read of a cell falls in the same cycle as the write of the complement to that same cell, in every element that reads and then writes. A bad design could compare against the new data, or let the write disturb the captured result. The bench provokes this with behavioural RAMs that hold injected faults: a stuck-at-1 bit, a stuck-at-0 bit, and a bridge between two bits of one word that only a non-uniform background exposes. The result is judged by the exact fail_vec value, and a scoreboard checks every address, write enable and write word against an independently built March list. A second start pulse is also injected in the middle of a run, in the same cycle as normal sequencing, and must leave the run length and the result unchanged.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    // One March operation: read or write, and whether it uses the complement.
    typedef struct packed {
        logic rd;
        logic inv;
    } mop_t;

    // One March element: direction, operation count, and its operations.
    typedef struct packed {
        logic up;
        logic two;
        mop_t first;
        mop_t second;
    } melem_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_DRAIN = 2'd2
    } seq_state_t;

    localparam int ELEM_CNT = 7;
    localparam logic [2:0] LAST_ELEM = 3'(ELEM_CNT - 1);

    function automatic melem_t elem_info(input logic [2:0] e);
        melem_t m;
        case (e)
            3'd0:    m = '{up: 1'b1, two: 1'b0, first: '{1'b0, 1'b0}, second: '{1'b0, 1'b0}};
            3'd1:    m = '{up: 1'b1, two: 1'b1, first: '{1'b1, 1'b0}, second: '{1'b0, 1'b1}};
            3'd2:    m = '{up: 1'b1, two: 1'b1, first: '{1'b1, 1'b1}, second: '{1'b0, 1'b0}};
            3'd3:    m = '{up: 1'b1, two: 1'b0, first: '{1'b1, 1'b0}, second: '{1'b0, 1'b0}};
            3'd4:    m = '{up: 1'b0, two: 1'b1, first: '{1'b1, 1'b0}, second: '{1'b0, 1'b1}};
            3'd5:    m = '{up: 1'b0, two: 1'b1, first: '{1'b1, 1'b1}, second: '{1'b0, 1'b0}};
            default: m = '{up: 1'b1, two: 1'b0, first: '{1'b1, 1'b0}, second: '{1'b0, 1'b0}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              idle,
    output logic              run,
    output logic              accept,
    output logic              done,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              op_we,
    output logic              op_rd
);
    localparam int NBG  = $clog2(DATA_W) + 1;
    localparam int BG_W = (NBG > 1) ? $clog2(NBG) : 1;
    localparam logic [BG_W-1:0] LAST_BG = BG_W'(NBG - 1);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    seq_state_t        state_q;
    logic [2:0]        elem_q;
    logic              ph_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BG_W-1:0]   bg_q;
    logic              done_q;

    melem_t            cur;
    melem_t            nxt;
    mop_t              op;
    logic [DATA_W-1:0] bg_word;
    logic              last_op, at_end;

    always_comb begin
        cur = elem_info(elem_q);
        nxt = elem_info(elem_q + 3'd1);
        op  = ph_q ? cur.second : cur.first;
        for (int i = 0; i < DATA_W; i++) begin
            if (bg_q == '0) bg_word[i] = 1'b0;
            else            bg_word[i] = ~((i >> (int'(bg_q) - 1)) & 1);
        end
        last_op = ph_q || !cur.two;
        at_end  = cur.up ? (addr_q == TOP_ADDR) : (addr_q == '0);
    end

    assign idle    = (state_q == S_IDLE);
    assign run     = (state_q == S_RUN);
    assign accept  = idle && start;
    assign done    = done_q;
    assign op_addr = addr_q;
    assign op_data = op.inv ? ~bg_word : bg_word;
    assign op_we   = run && !op.rd;
    assign op_rd   = run && op.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            elem_q  <= '0;
            ph_q    <= 1'b0;
            addr_q  <= '0;
            bg_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        state_q <= S_RUN;
                        elem_q  <= '0;
                        ph_q    <= 1'b0;
                        addr_q  <= '0;
                        bg_q    <= '0;
                        done_q  <= 1'b0;
                    end
                end
                S_RUN: begin
                    if (!last_op) begin
                        ph_q <= 1'b1;
                    end else begin
                        ph_q <= 1'b0;
                        if (!at_end) begin
                            addr_q <= cur.up ? addr_q + 1'b1 : addr_q - 1'b1;
                        end else if (elem_q != LAST_ELEM) begin
                            elem_q <= elem_q + 3'd1;
                            addr_q <= nxt.up ? '0 : TOP_ADDR;
                        end else if (bg_q != LAST_BG) begin
                            bg_q   <= bg_q + 1'b1;
                            elem_q <= '0;
                            addr_q <= '0;
                        end else begin
                            state_q <= S_DRAIN;
                        end
                    end
                end
                S_DRAIN: begin
                    state_q <= S_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
    parameter int NUM_RAMS = 2,
    parameter int DATA_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       rd_issue,
    input  logic [DATA_W-1:0]          exp_data,
    input  logic [NUM_RAMS*DATA_W-1:0] rdata,
    output logic [NUM_RAMS-1:0]        fail_vec
);
    logic              rd_q;
    logic [DATA_W-1:0] exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            exp_q <= '0;
        end else begin
            rd_q  <= rd_issue;
            exp_q <= exp_data;
        end
    end

    for (genvar r = 0; r < NUM_RAMS; r++) begin : g_lane
        logic miss;
        logic fail_q;
        assign miss = rd_q && (rdata[r*DATA_W +: DATA_W] != exp_q);
        always_ff @(posedge clk) begin
            if (rst || clear) fail_q <= 1'b0;
            else              fail_q <= fail_q | miss;
        end
        assign fail_vec[r] = fail_q;
    end

endmodule

// File: rtl/mbist_port_mux.sv
module mbist_port_mux #(
    parameter int NUM_RAMS = 2,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8
) (
    input  logic                       sel_test,
    input  logic [ADDR_W-1:0]          t_addr,
    input  logic [DATA_W-1:0]          t_data,
    input  logic                       t_we,
    input  logic [NUM_RAMS*ADDR_W-1:0] f_addr,
    input  logic [NUM_RAMS*DATA_W-1:0] f_data,
    input  logic [NUM_RAMS-1:0]        f_we,
    output logic [NUM_RAMS*ADDR_W-1:0] o_addr,
    output logic [NUM_RAMS*DATA_W-1:0] o_data,
    output logic [NUM_RAMS-1:0]        o_we
);
    for (genvar r = 0; r < NUM_RAMS; r++) begin : g_leg
        assign o_addr[r*ADDR_W +: ADDR_W] = sel_test ? t_addr : f_addr[r*ADDR_W +: ADDR_W];
        assign o_data[r*DATA_W +: DATA_W] = sel_test ? t_data : f_data[r*DATA_W +: DATA_W];
        assign o_we[r]                    = sel_test ? t_we   : f_we[r];
    end
endmodule

// File: rtl/mbist_engine.sv
module mbist_engine #(
    parameter int NUM_RAMS = 2,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    output logic                       done,
    output logic                       fail,
    output logic [NUM_RAMS-1:0]        fail_vec,
    input  logic [NUM_RAMS*ADDR_W-1:0] sys_addr,
    input  logic [NUM_RAMS*DATA_W-1:0] sys_wdata,
    input  logic [NUM_RAMS-1:0]        sys_we,
    output logic [NUM_RAMS*ADDR_W-1:0] ram_addr,
    output logic [NUM_RAMS*DATA_W-1:0] ram_wdata,
    output logic [NUM_RAMS-1:0]        ram_we,
    input  logic [NUM_RAMS*DATA_W-1:0] ram_rdata
);
    logic              idle, run, accept, op_we, op_rd;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;

    mbist_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
        .clk(clk), .rst(rst), .start(start),
        .idle(idle), .run(run), .accept(accept), .done(done),
        .op_addr(op_addr), .op_data(op_data), .op_we(op_we), .op_rd(op_rd)
    );

    mbist_cmp #(.NUM_RAMS(NUM_RAMS), .DATA_W(DATA_W)) cmp_i (
        .clk(clk), .rst(rst), .clear(accept), .rd_issue(op_rd),
        .exp_data(op_data), .rdata(ram_rdata), .fail_vec(fail_vec)
    );

    mbist_port_mux #(.NUM_RAMS(NUM_RAMS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) mux_i (
        .sel_test(run), .t_addr(op_addr), .t_data(op_data), .t_we(op_we),
        .f_addr(sys_addr), .f_data(sys_wdata), .f_we(sys_we),
        .o_addr(ram_addr), .o_data(ram_wdata), .o_we(ram_we)
    );

    assign fail = |fail_vec;

endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk #(
    parameter int NUM_RAMS = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                idle,
    input logic                run,
    input logic                done,
    input logic [NUM_RAMS-1:0] fail_vec
);
    a_r8_no_done_while_run: assert property (@(posedge clk) disable iff (rst)
        run |-> !done);

    a_r8_done_after_run: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(run, 2));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        (start && idle) |=> (run && !done && fail_vec == '0));

    a_r6_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        !(start && idle) |=> ((fail_vec & $past(fail_vec)) == $past(fail_vec)));

    a_r8_result_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fail_vec)));
endmodule

bind mbist_engine mbist_engine_chk #(.NUM_RAMS(NUM_RAMS)) chk_i (
    .clk(clk), .rst(rst), .start(start), .idle(idle), .run(run),
    .done(done), .fail_vec(fail_vec)
);

// File: tb/mbist_engine_tb_top.sv
module mbist_engine_tb_top;
    localparam int NR = 2;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int NBG = $clog2(DW) + 1;
    localparam int RUN_EDGES = 11 * DEPTH * NBG + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             done, fail;
    logic [NR-1:0]    fail_vec;
    logic [NR*AW-1:0] sys_addr = '0;
    logic [NR*DW-1:0] sys_wdata = '0;
    logic [NR-1:0]    sys_we = '0;
    logic [NR*AW-1:0] ram_addr;
    logic [NR*DW-1:0] ram_wdata;
    logic [NR-1:0]    ram_we;
    logic [NR*DW-1:0] ram_rdata = '0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mbist_engine #(.NUM_RAMS(NR), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail),
        .fail_vec(fail_vec), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
        .sys_we(sys_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_we(ram_we), .ram_rdata(ram_rdata)
    );

    // Behavioural RAMs with one injectable fault.
    logic [DW-1:0] mem [NR][DEPTH];
    int f_kind = 0;   // 0 none, 1 stuck-at-1, 2 stuck-at-0, 3 bit1 follows bit0
    int f_ram = 0, f_addr = 0, f_bit = 0;

    function automatic logic [DW-1:0] stored(int r, int a, logic [DW-1:0] d);
        logic [DW-1:0] v = d;
        if (r == f_ram && a == f_addr) begin
            case (f_kind)
                1: v[f_bit] = 1'b1;
                2: v[f_bit] = 1'b0;
                3: v[1] = v[0];
                default: ;
            endcase
        end
        return v;
    endfunction

    always @(posedge clk) begin
        for (int r = 0; r < NR; r++) begin
            int a;
            a = int'(ram_addr[r*AW +: AW]);
            ram_rdata[r*DW +: DW] <= mem[r][a];
            if (ram_we[r]) mem[r][a] <= stored(r, a, ram_wdata[r*DW +: DW]);
        end
    end

    // Scoreboard of expected port operations.
    typedef struct { int addr; bit we; logic [DW-1:0] data; } op_item_t;
    op_item_t exp_q[$];
    bit mon_on = 0;
    int seq_errs = 0;

    function automatic logic [DW-1:0] bgpat(int k);
        logic [DW-1:0] w;
        for (int i = 0; i < DW; i++) w[i] = (k == 0) ? 1'b0 : (((i >> (k - 1)) & 1) == 0);
        return w;
    endfunction

    // Codes: 0 r0, 1 r1, 2 w0, 3 w1, -1 none (R3 element list)
    int e_up  [7] = '{1, 1, 1, 1, 0, 0, 1};
    int e_op0 [7] = '{2, 0, 1, 0, 0, 1, 0};
    int e_op1 [7] = '{-1, 3, 2, -1, 3, 2, -1};

    task automatic push_march();
        exp_q.delete();
        for (int k = 0; k < NBG; k++) begin
            for (int e = 0; e < 7; e++) begin
                for (int s = 0; s < DEPTH; s++) begin
                    int a;
                    a = e_up[e] ? s : DEPTH - 1 - s;
                    for (int p = 0; p < 2; p++) begin
                        int c;
                        op_item_t it;
                        c = (p == 0) ? e_op0[e] : e_op1[e];
                        if (c >= 0) begin
                            it.addr = a;
                            it.we = (c >= 2);
                            it.data = (c % 2) ? ~bgpat(k) : bgpat(k);
                            exp_q.push_back(it);
                        end
                    end
                end
            end
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (exp_q.size() == 0) begin
                mon_on = 0;
            end else begin
                op_item_t it;
                bit bad;
                it = exp_q.pop_front();
                bad = 0;
                for (int r = 0; r < NR; r++) begin
                    if (int'(ram_addr[r*AW +: AW]) != it.addr || ram_we[r] != it.we) bad = 1;
                    if (it.we && ram_wdata[r*DW +: DW] != it.data) bad = 1;
                end
                tests++;
                if (bad) begin
                    fails++;
                    seq_errs++;
                    if (seq_errs < 6)
                        $display("FAIL R3/R4/R5 op: addr=%0d we=%0b wdata=%h expected addr=%0d we=%0b wdata=%h",
                                 ram_addr[AW-1:0], ram_we[0], ram_wdata[DW-1:0], it.addr, it.we, it.data);
                end
                if (exp_q.size() == 0) mon_on = 0;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_test(logic [NR-1:0] exp_fv, bit poke);
        int n;
        push_march();
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        #1 mon_on = 1;
        @(negedge clk) start = 1'b0;
        check("R2 done cleared by start", 32'(done), 32'd0);
        n = 0;
        while (!done && n < 2000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (poke && n == 100) start = 1'b1;
            if (poke && n == 101) start = 1'b0;
        end
        check("R8 edges from start to done", 32'(n), 32'(RUN_EDGES));
        check("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
        check("R6 fail_vec", 32'(fail_vec), 32'(exp_fv));
        check("R7 fail", 32'(fail), 32'(exp_fv != '0));
        repeat (5) @(negedge clk);
        check("R8 done holds", 32'(done), 32'd1);
        check("R8 fail_vec holds", 32'(fail_vec), 32'(exp_fv));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset done", 32'(done), 32'd0);
        check("R6 reset fail_vec", 32'(fail_vec), 32'd0);
        check("R7 reset fail", 32'(fail), 32'd0);

        // R1: functional path when idle
        sys_addr = {4'hA, 4'h3};
        sys_wdata = {8'h5C, 8'hC3};
        sys_we = 2'b01;
        #1;
        check("R1 addr passthrough", 32'(ram_addr), 32'(8'hA3));
        check("R1 wdata passthrough", 32'(ram_wdata), 32'(16'h5CC3));
        check("R1 we passthrough", 32'(ram_we), 32'(2'b01));
        @(negedge clk) sys_we = '0;

        // Fault-free run with a stray start mid-run (R2)
        f_kind = 0;
        run_test(2'b00, 1'b1);

        // R6: stuck-at-1 in RAM1
        f_kind = 1; f_ram = 1; f_addr = 5; f_bit = 3;
        run_test(2'b10, 1'b0);

        // R6/R2: stuck-at-0 in RAM0, previous fail must be cleared
        f_kind = 2; f_ram = 0; f_addr = 0; f_bit = 0;
        run_test(2'b01, 1'b0);

        // R4: intra-word bridge seen only with a non-uniform background
        f_kind = 3; f_ram = 1; f_addr = 9;
        run_test(2'b10, 1'b0);

        // R1 after a test
        sys_addr = {4'h7, 4'hE};
        #1;
        check("R1 addr after test", 32'(ram_addr), 32'(8'h7E));

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 100000 && !finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule